// File: doc/BRIEF.md
# Memory Chip-Enable Gate with Reset Grace Window

This block sits on the active-low chip-enable path between a processor and an external low-power SRAM. Outside reset it is transparent: the conditioned enable follows the processor's enable with no clock in the path. While the supervisor's reset-active flag is high, the memory is write-protected because the conditioned enable is held inactive.

The block does not cut off an access that is already under way when reset begins. If the processor enable is already low in the first cycle of reset, that access keeps the memory selected for a bounded grace window of `GRACE_TICKS` clock cycles. The window is 15 µs of clock ticks, which is 750 at 50 MHz. The window ends early if the processor drops its enable. Once the window is over, the memory stays deselected until the reset flag falls. Each new reset assertion arms a fresh window.

Top module: `ce_gate_top`

## Requirements
- R1: While `rst_active` is 0, `ce_out_n` equals `ce_in_n` in the same cycle, with no register in the path.
- R2: `ce_out_n` is 0 only when `ce_in_n` is 0.
- R3: If `ce_in_n` is 0 in the first cycle that `rst_active` is 1, and stays 0, then `ce_out_n` stays 0 for exactly `GRACE_TICKS` cycles, counting that first cycle. It is 1 from cycle `GRACE_TICKS` on.
- R4: If `ce_in_n` returns to 1 during the grace window, the window closes. A later 0 on `ce_in_n` in the same reset period leaves `ce_out_n` at 1.
- R5: An enable that first goes to 0 after the first cycle of reset is never passed: `ce_out_n` stays 1.
- R6: After the window has closed, `ce_out_n` stays 1 for as long as `rst_active` stays 1.
- R7: Every new rising edge of `rst_active` arms a full-length window again.
- R8: When `rst_active` falls while `ce_in_n` is 0, `ce_out_n` is 0 in that same cycle. This also holds when the fall coincides with the window's expiry.
- R9: `rst_n` is a synchronous active-low reset that clears the window state. If `rst_active` is already 1 and `ce_in_n` is 0 when `rst_n` releases, a full window is granted starting with that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the gate's own state |
| ce_in_n | input | 1 | Processor chip-enable, active low |
| rst_active | input | 1 | Supervisor reset-active flag, active high |
| ce_out_n | output | 1 | Conditioned chip-enable to the memory, active low |

## Verification
Several events can land in the same cycle: the grace counter reaching its limit, the processor releasing its enable, and the reset flag falling. The bench raises the enable in the last granted cycle of the window and expects it to be honoured at once. It also drops the reset flag in exactly the cycle where the window expires, with the enable still low, and expects the memory to be selected in that cycle rather than blocked. A checker counts the consecutive selected cycles during reset and bounds them by the window length.

// File: rtl/ce_gate_pkg.sv
// Package: shared helpers for the chip-enable gate.
// Assumes: counters are sized to hold values 0..limit inclusive.
package ce_gate_pkg;

    // Width of a counter that must hold the value lim.
    function automatic int cnt_width(input int lim);
        return (lim < 1) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/ce_gate_edge.sv
// Module: rising-edge detector for the reset-active flag.
// It flags the first cycle in which lvl is high after a cycle in which it was
// low. The detector's state clears on a synchronous reset, so a level that is
// already high when reset releases counts as a new edge.
module ce_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);

    logic lvl_q;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/ce_gate_window.sv
// Module: grace-window timer.
// When reset starts (start=1) with the enable low, it grants up to
// GRACE_TICKS cycles, counting the start cycle. The window closes for the rest
// of the reset period once the enable goes high or the count is used up.
// Assumes: in_reset is high whenever start is high.
module ce_gate_window
    import ce_gate_pkg::*;
#(
    parameter int GRACE_TICKS = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_reset,
    input  logic ce_low,
    output logic open
);

    localparam int CW = cnt_width(GRACE_TICKS);
    localparam logic [CW-1:0] LIMIT = CW'(GRACE_TICKS);

    logic          run_q;
    logic [CW-1:0] cnt_q;

    assign open = in_reset & ce_low & (start | (run_q & (cnt_q < LIMIT)));

    // Track the running window and its elapsed cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (!in_reset) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= ce_low;
            cnt_q <= CW'(1);
        end else if (run_q && (!ce_low || cnt_q >= LIMIT)) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/ce_gate_top.sv
// Module: chip-enable gate for an external SRAM.
// Outside reset the enable passes through combinationally. During reset it is
// blocked, except for an access already in progress at reset onset, which
// keeps a bounded grace window.
// Assumes: rst_active is synchronous to clk; GRACE_TICKS >= 1.
module ce_gate_top #(
    parameter int GRACE_TICKS = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_in_n,
    input  logic rst_active,
    output logic ce_out_n
);

    logic rst_rise;
    logic grace_open;

    ce_gate_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (rst_active),
        .rise  (rst_rise)
    );

    ce_gate_window #(.GRACE_TICKS(GRACE_TICKS)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (rst_rise),
        .in_reset (rst_active),
        .ce_low   (~ce_in_n),
        .open     (grace_open)
    );

    // Block the enable during reset unless the grace window is open.
    always_comb begin
        ce_out_n = ce_in_n | (rst_active & ~grace_open);
    end

endmodule

// File: rtl/ce_gate_chk.sv
// Module: property checker for ce_gate_top, attached with bind below.
// It holds a run counter of consecutive selected cycles during reset, which
// bounds the grace window without a parameter-deep delay.
module ce_gate_chk
    import ce_gate_pkg::*;
#(
    parameter int GRACE_TICKS = 750
) (
    input logic clk,
    input logic rst_n,
    input logic ce_in_n,
    input logic rst_active,
    input logic ce_out_n
);

    localparam int CW = cnt_width(GRACE_TICKS);

    logic [CW-1:0] low_run;

    // Count consecutive cycles in reset with the memory selected.
    always_ff @(posedge clk) begin
        if (!rst_n)                               low_run <= '0;
        else if (rst_active && !ce_out_n && low_run < CW'(GRACE_TICKS))
                                                  low_run <= low_run + CW'(1);
        else if (!(rst_active && !ce_out_n))      low_run <= '0;
    end

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_active |-> (ce_out_n == ce_in_n));

    // R2
    no_spurious_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_out_n |-> !ce_in_n);

    // R3
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_active && !ce_out_n) |-> (low_run < CW'(GRACE_TICKS)));

    // R5
    new_enable_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_active && $past(rst_active) && $past(ce_in_n)) |-> ce_out_n);

    // R6
    stays_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_active && $past(rst_active) && $past(ce_out_n)) |-> ce_out_n);

endmodule

bind ce_gate_top ce_gate_chk #(.GRACE_TICKS(GRACE_TICKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_in_n    (ce_in_n),
    .rst_active (rst_active),
    .ce_out_n   (ce_out_n)
);

// File: tb/sim_ce_gate_top.sv
// Bench: directed scenarios for ce_gate_top, one task each.
// Inputs change 1 ns after a rising edge; outputs are sampled at the falling edge.
module sim_ce_gate_top;

    localparam int G = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_in_n = 1'b1;
    logic rst_active = 1'b0;
    logic ce_out_n;

    int n_chk = 0;
    int n_bad = 0;

    ce_gate_top #(.GRACE_TICKS(G)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_in_n    (ce_in_n),
        .rst_active (rst_active),
        .ce_out_n   (ce_out_n)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Sample at the falling edge, compare, then move to just after the next rising edge.
    task automatic chk(input logic exp, input string tag);
        @(negedge clk);
        n_chk++;
        if (ce_out_n !== exp) begin
            n_bad++;
            $display("FAIL %s: ce_out_n=%b expected %b at %0t", tag, ce_out_n, exp, $time);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset_state();
        rst_active = 1'b0; ce_in_n = 1'b1;
        chk(1'b1, "R1 idle after reset");
        ce_in_n = 1'b0;
        chk(1'b0, "R1 select passes");
        ce_in_n = 1'b1;
        chk(1'b1, "R1 deselect passes");
    endtask

    task automatic t_full_window();
        ce_in_n = 1'b0;
        chk(1'b0, "R1 select before reset");
        rst_active = 1'b1;
        for (int k = 0; k < G; k++) chk(1'b0, "R3 grace cycle");
        chk(1'b1, "R3 window expired");
        for (int k = 0; k < 3; k++) chk(1'b1, "R6 blocked after expiry");
        rst_active = 1'b0;
        chk(1'b0, "R8 release with enable low");
        ce_in_n = 1'b1;
        chk(1'b1, "R2 deselect");
    endtask

    task automatic t_early_end();
        ce_in_n = 1'b0;
        rst_active = 1'b1;
        chk(1'b0, "R3 start of window");
        chk(1'b0, "R3 second cycle");
        ce_in_n = 1'b1;
        chk(1'b1, "R4 enable released");
        ce_in_n = 1'b0;
        for (int k = 0; k < G + 2; k++) chk(1'b1, "R4 reselect blocked");
        rst_active = 1'b0;
        chk(1'b0, "R8 release");
        ce_in_n = 1'b1;
        chk(1'b1, "R1 idle");
    endtask

    task automatic t_last_cycle_release();
        ce_in_n = 1'b0;
        rst_active = 1'b1;
        for (int k = 0; k < G - 1; k++) chk(1'b0, "R3 grace cycle");
        ce_in_n = 1'b1;
        chk(1'b1, "R4 release on last grace cycle");
        ce_in_n = 1'b0;
        chk(1'b1, "R4 reselect blocked");
        rst_active = 1'b0; ce_in_n = 1'b1;
        chk(1'b1, "R1 idle");
    endtask

    task automatic t_new_enable();
        ce_in_n = 1'b1;
        rst_active = 1'b1;
        chk(1'b1, "R5 reset onset idle");
        chk(1'b1, "R5 idle in reset");
        ce_in_n = 1'b0;
        for (int k = 0; k < G + 1; k++) chk(1'b1, "R5 new enable blocked");
        rst_active = 1'b0;
        chk(1'b0, "R8 release passes enable");
        ce_in_n = 1'b1;
        chk(1'b1, "R1 idle");
    endtask

    task automatic t_expiry_meets_release();
        ce_in_n = 1'b0;
        rst_active = 1'b1;
        for (int k = 0; k < G; k++) chk(1'b0, "R7 fresh window cycle");
        rst_active = 1'b0;
        chk(1'b0, "R8 release at expiry cycle");
        rst_active = 1'b1;
        for (int k = 0; k < G; k++) chk(1'b0, "R7 rearmed window cycle");
        chk(1'b1, "R7 rearmed window expired");
        rst_active = 1'b0; ce_in_n = 1'b1;
        chk(1'b1, "R1 idle");
    endtask

    task automatic t_sync_reset();
        rst_active = 1'b1; ce_in_n = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst_n = 1'b1;
        for (int k = 0; k < G; k++) chk(1'b0, "R9 window after rst_n");
        chk(1'b1, "R9 window expired after rst_n");
        rst_active = 1'b0; ce_in_n = 1'b1;
        chk(1'b1, "R1 idle");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset_state();
        t_full_window();
        t_early_end();
        t_last_cycle_release();
        t_new_enable();
        t_expiry_meets_release();
        t_sync_reset();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule